// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block feeds a downstream asynchronous HDLC framer from a ring of transmit descriptors. Each descriptor sits in a small internal descriptor memory and names a byte buffer in a separate buffer memory. The sequencer polls the current descriptor for its ownership flag. It streams the buffer's bytes over a valid/ready byte interface and tells the framer where a frame ends, so that the framer can append the check sequence and the closing flag. It then hands the descriptor back to the host and moves on around the ring.

The ring has no length register. A descriptor carrying the wrap flag sends the sequencer back to slot 0, so the host sets the ring size by where it places that flag. The host fills descriptors and buffers through plain write ports, reads descriptors back through a read port, and watches a sticky transmit-buffer event. A downstream abort, such as a lost clear-to-send, cuts the current buffer short and marks the descriptor as failed.

Top module: `txbd_ring_seq`

## Requirements
- R1: After reset, `tx_valid`, `tx_eof` and `tx_event` are 0, every descriptor halfword reads 0, and the first descriptor taken is slot 0.
- R2: Each descriptor is four 16-bit halfwords at halfword address slot*4. Offset 0 holds the control word: bit 15 ready, bit 13 wrap, bit 12 event request, bit 11 last, bit 1 error. Offset 1 holds the byte count. Offsets 2 and 3 hold the upper and lower halves of the buffer pointer, and the buffer address is the pointer modulo the buffer depth.
- R3: While the current descriptor's ready bit is 0, no byte is offered and the sequencer keeps polling that same slot, even when later slots are ready.
- R4: A buffer's bytes are offered in increasing address order from the pointer, one per cycle in which `tx_valid` and `tx_ready` are both high. Data stays stable while `tx_valid` waits for `tx_ready`.
- R5: After the final byte of a buffer with the last bit set, `tx_eof` pulses high for exactly one cycle and `tx_valid` is low during it. A buffer without the last bit produces no pulse, so the next buffer continues the same frame.
- R6: A zero-length descriptor offers no bytes. It still pulses `tx_eof` if its last bit is set, and retires directly if it is not.
- R7: When a descriptor retires, its control word is rewritten with the ready bit cleared. All other bits are kept, and the byte count and pointer are left unchanged.
- R8: After a descriptor with the wrap bit retires, the next slot polled is 0. Otherwise it is the following slot, modulo the number of slots.
- R9: Retiring a descriptor whose event-request bit is set makes `tx_event` 1. This applies to an aborted descriptor too. `tx_event` stays 1 until cleared, and retiring descriptors without that bit never sets it.
- R10: A one-cycle pulse on `evt_clr` clears `tx_event`. If a new event arrives in the same cycle, the event wins.
- R11: `tx_abort` high while a byte is offered ends the buffer at once. No byte transfers in that cycle, and no `tx_eof` pulse follows. The descriptor retires with ready cleared and the error bit set, and the sequencer advances to the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_wr_en | input | 1 | Host write strobe for descriptor memory |
| desc_wr_addr | input | DESC_AW | Host write halfword address |
| desc_wr_data | input | 16 | Host write halfword |
| desc_rd_addr | input | DESC_AW | Host read halfword address |
| desc_rd_data | output | 16 | Host read halfword (combinational) |
| buf_wr_en | input | 1 | Host write strobe for buffer memory |
| buf_wr_addr | input | BUF_AW | Host buffer byte address |
| buf_wr_data | input | 8 | Host buffer byte |
| evt_clr | input | 1 | Write-one-to-clear pulse for the event flag |
| tx_event | output | 1 | Sticky transmit-buffer event |
| tx_valid | output | 1 | Byte offered to the framer |
| tx_ready | input | 1 | Framer accepts the offered byte |
| tx_data | output | 8 | Offered byte |
| tx_eof | output | 1 | One-cycle end-of-frame strobe (append check sequence and flag) |
| tx_abort | input | 1 | Framer abort of the current buffer |

## Verification
The bench builds the block with its defaults: 8 descriptor slots and a 256-byte buffer. Rings of one to four slots therefore fit, with wrap points at every position. Twelve passes sweep ring length, byte counts from 0 to 5 and three framer-ready patterns. Together they cover zero-length buffers with and without the last bit, frames spanning several buffers, and rings with and without event requests. Separate runs check that the sequencer holds on a non-ready slot while a later slot is ready, and check an abort in the middle of a buffer.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

    // Control-word bit positions (halfword 0 of each descriptor)
    localparam int BIT_READY = 15;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_INTR  = 12;
    localparam int BIT_LAST  = 11;
    localparam int BIT_ERR   = 1;

    // Halfword offsets inside one descriptor
    localparam int HW_PER_DESC = 4;
    localparam int OFS_CTRL    = 0;
    localparam int OFS_LEN     = 1;
    localparam int OFS_PTR_HI  = 2;
    localparam int OFS_PTR_LO  = 3;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] length;
        logic [31:0] pointer;
    } desc_t;

    typedef enum logic [1:0] {
        S_POLL   = 2'd0,
        S_SEND   = 2'd1,
        S_EOF    = 2'd2,
        S_RETIRE = 2'd3
    } seq_state_t;

    // Control word written back when a descriptor is handed to the host
    function automatic logic [15:0] retire_word(input logic [15:0] ctrl,
                                                input logic        failed);
        logic [15:0] w;
        w            = ctrl;
        w[BIT_READY] = 1'b0;
        if (failed) w[BIT_ERR] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/txbd_desc_mem.sv
module txbd_desc_mem
    import txbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int WORDS   = NUM_DESC * HW_PER_DESC,
    localparam int AW      = $clog2(WORDS),
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [AW-1:0]    host_waddr,
    input  logic [15:0]      host_wdata,
    input  logic [AW-1:0]    host_raddr,
    output logic [15:0]      host_rdata,
    input  logic [IDX_W-1:0] seq_idx,
    output desc_t            seq_desc,
    input  logic             seq_we,
    input  logic [15:0]      seq_ctrl
);

    logic [15:0] mem [WORDS];

    // Sequencer write-back is placed last so it wins on an address clash
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_waddr] <= host_wdata;
            if (seq_we)  mem[{seq_idx, 2'(OFS_CTRL)}] <= seq_ctrl;
        end
    end

    assign host_rdata = mem[host_raddr];

    always_comb begin
        seq_desc.ctrl    = mem[{seq_idx, 2'(OFS_CTRL)}];
        seq_desc.length  = mem[{seq_idx, 2'(OFS_LEN)}];
        seq_desc.pointer = {mem[{seq_idx, 2'(OFS_PTR_HI)}],
                            mem[{seq_idx, 2'(OFS_PTR_LO)}]};
    end

endmodule

// File: rtl/txbd_buf_mem.sv
module txbd_buf_mem #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/txbd_evt_flag.sv
module txbd_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/txbd_seq_ctrl.sv
module txbd_seq_ctrl
    import txbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int BUF_AW   = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  desc_t             desc,
    output logic [IDX_W-1:0]  idx,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              byte_valid,
    input  logic              byte_ready,
    input  logic              abort,
    output logic              eof,
    output logic              wb_we,
    output logic [15:0]       wb_ctrl,
    output logic              retire_evt
);

    seq_state_t  state;
    logic [31:0] ptr;
    logic [15:0] remain;
    logic [15:0] cur_ctrl;
    logic        aborted;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_POLL;
            idx      <= '0;
            ptr      <= '0;
            remain   <= '0;
            cur_ctrl <= '0;
            aborted  <= 1'b0;
        end else begin
            unique case (state)
                S_POLL: begin
                    if (desc.ctrl[BIT_READY]) begin
                        cur_ctrl <= desc.ctrl;
                        ptr      <= desc.pointer;
                        remain   <= desc.length;
                        if (desc.length == '0)
                            state <= desc.ctrl[BIT_LAST] ? S_EOF : S_RETIRE;
                        else
                            state <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (abort) begin
                        aborted <= 1'b1;
                        state   <= S_RETIRE;
                    end else if (byte_ready) begin
                        ptr    <= ptr + 32'd1;
                        remain <= remain - 16'd1;
                        if (remain == 16'd1)
                            state <= cur_ctrl[BIT_LAST] ? S_EOF : S_RETIRE;
                    end
                end
                S_EOF: begin
                    state <= S_RETIRE;
                end
                S_RETIRE: begin
                    aborted <= 1'b0;
                    idx     <= cur_ctrl[BIT_WRAP] ? '0 : idx + 1'b1;
                    state   <= S_POLL;
                end
                default: state <= S_POLL;
            endcase
        end
    end

    always_comb begin
        buf_addr   = ptr[BUF_AW-1:0];
        byte_valid = (state == S_SEND);
        eof        = (state == S_EOF);
        wb_we      = (state == S_RETIRE);
        wb_ctrl    = retire_word(cur_ctrl, aborted);
        retire_evt = wb_we & cur_ctrl[BIT_INTR];
    end

endmodule

// File: rtl/txbd_ring_seq.sv
module txbd_ring_seq
    import txbd_pkg::*;
#(
    parameter int NUM_DESC  = 8,
    parameter int BUF_DEPTH = 256,
    localparam int DESC_AW  = $clog2(NUM_DESC * HW_PER_DESC),
    localparam int BUF_AW   = $clog2(BUF_DEPTH),
    localparam int IDX_W    = $clog2(NUM_DESC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_wr_en,
    input  logic [DESC_AW-1:0] desc_wr_addr,
    input  logic [15:0]        desc_wr_data,
    input  logic [DESC_AW-1:0] desc_rd_addr,
    output logic [15:0]        desc_rd_data,
    input  logic               buf_wr_en,
    input  logic [BUF_AW-1:0]  buf_wr_addr,
    input  logic [7:0]         buf_wr_data,
    input  logic               evt_clr,
    output logic               tx_event,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_eof,
    input  logic               tx_abort
);

    desc_t             cur_desc;
    logic [IDX_W-1:0]  cur_idx;
    logic [BUF_AW-1:0] rd_addr;
    logic              wb_we;
    logic [15:0]       wb_ctrl;
    logic              retire_evt;

    txbd_desc_mem #(.NUM_DESC(NUM_DESC)) u_desc (
        .clk        (clk),
        .rst        (rst),
        .host_we    (desc_wr_en),
        .host_waddr (desc_wr_addr),
        .host_wdata (desc_wr_data),
        .host_raddr (desc_rd_addr),
        .host_rdata (desc_rd_data),
        .seq_idx    (cur_idx),
        .seq_desc   (cur_desc),
        .seq_we     (wb_we),
        .seq_ctrl   (wb_ctrl)
    );

    txbd_buf_mem #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .we    (buf_wr_en),
        .waddr (buf_wr_addr),
        .wdata (buf_wr_data),
        .raddr (rd_addr),
        .rdata (tx_data)
    );

    txbd_seq_ctrl #(.NUM_DESC(NUM_DESC), .BUF_AW(BUF_AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .desc       (cur_desc),
        .idx        (cur_idx),
        .buf_addr   (rd_addr),
        .byte_valid (tx_valid),
        .byte_ready (tx_ready),
        .abort      (tx_abort),
        .eof        (tx_eof),
        .wb_we      (wb_we),
        .wb_ctrl    (wb_ctrl),
        .retire_evt (retire_evt)
    );

    txbd_evt_flag u_evt (
        .clk  (clk),
        .rst  (rst),
        .set  (retire_evt),
        .clr  (evt_clr),
        .flag (tx_event)
    );

endmodule

// File: rtl/txbd_ring_seq_chk.sv
module txbd_ring_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_eof,
    input logic       tx_abort,
    input logic       tx_event,
    input logic       evt_clr,
    input logic       retire_evt
);

    // R4: an offered byte is held until taken or aborted
    p_hold_byte_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !tx_abort) |=> (tx_valid && $stable(tx_data)));

    // R5: end-of-frame strobe lasts one cycle
    p_eof_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        tx_eof |=> !tx_eof);

    // R5: no byte offered during the strobe
    p_eof_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(tx_eof && tx_valid));

    // R9: event flag is sticky
    p_evt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_event && !evt_clr) |=> tx_event);

    // R10: clear pulse drops the flag when no new event arrives
    p_evt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_clr && !retire_evt) |=> !tx_event);

    // R10: a new event wins over a clear
    p_evt_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        retire_evt |=> tx_event);

    // R11: abort ends the buffer and suppresses the strobe
    p_abort_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_abort) |=> (!tx_valid && !tx_eof));

endmodule

bind txbd_ring_seq txbd_ring_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_eof     (tx_eof),
    .tx_abort   (tx_abort),
    .tx_event   (tx_event),
    .evt_clr    (evt_clr),
    .retire_evt (retire_evt)
);

// File: tb/tb_txbd_ring_seq.sv
module tb_txbd_ring_seq;

    localparam int NUM_DESC  = 8;
    localparam int BUF_DEPTH = 256;
    localparam int DESC_AW   = $clog2(NUM_DESC * 4);
    localparam int BUF_AW    = $clog2(BUF_DEPTH);

    localparam logic [15:0] C_READY = 16'h8000;
    localparam logic [15:0] C_WRAP  = 16'h2000;
    localparam logic [15:0] C_INTR  = 16'h1000;
    localparam logic [15:0] C_LAST  = 16'h0800;
    localparam logic [15:0] C_ERR   = 16'h0002;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               desc_wr_en = 1'b0;
    logic [DESC_AW-1:0] desc_wr_addr = '0;
    logic [15:0]        desc_wr_data = '0;
    logic [DESC_AW-1:0] desc_rd_addr = '0;
    logic [15:0]        desc_rd_data;
    logic               buf_wr_en = 1'b0;
    logic [BUF_AW-1:0]  buf_wr_addr = '0;
    logic [7:0]         buf_wr_data = '0;
    logic               evt_clr = 1'b0;
    logic               tx_event;
    logic               tx_valid;
    logic               tx_ready = 1'b0;
    logic [7:0]         tx_data;
    logic               tx_eof;
    logic               tx_abort = 1'b0;

    txbd_ring_seq #(.NUM_DESC(NUM_DESC), .BUF_DEPTH(BUF_DEPTH)) dut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_pat = 0;
    bit abort_arm = 0;
    int abort_at = 0;
    logic [7:0] got_bytes [512];
    int got = 0;
    int eof_pos [32];
    int eof_n = 0;
    logic [7:0] exp_bytes [512];
    int exp_n = 0;
    int exp_eof [32];
    int exp_eof_n = 0;
    logic [15:0] ctl_v [8];

    function automatic logic [7:0] bval(input int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    // Framer model: drive inputs after the falling edge, then record
    always @(negedge clk) begin
        cyc++;
        if (ready_pat == 0) tx_ready = 1'b1;
        else                tx_ready = ((cyc * 5 + ready_pat) % 3) != 0;
        tx_abort = abort_arm && tx_valid && (got == abort_at);
        if (tx_abort) abort_arm = 0;
        #1;
        if (tx_valid && tx_ready && !tx_abort && got < 512) begin
            got_bytes[got] = tx_data;
            got++;
        end
        if (tx_eof && eof_n < 32) begin
            eof_pos[eof_n] = got;
            eof_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr_desc(input int a, input logic [15:0] d);
        @(negedge clk);
        desc_wr_addr = DESC_AW'(a);
        desc_wr_data = d;
        desc_wr_en   = 1'b1;
        @(negedge clk);
        desc_wr_en   = 1'b0;
    endtask

    task automatic rd_desc(input int a, output logic [15:0] d);
        desc_rd_addr = DESC_AW'(a);
        #2;
        d = desc_rd_data;
    endtask

    task automatic put_desc(input int slot, input logic [15:0] ctl, input int len, input int ptr);
        wr_desc(slot * 4 + 1, 16'(len));
        wr_desc(slot * 4 + 2, 16'(ptr >> 16));
        wr_desc(slot * 4 + 3, 16'(ptr));
        wr_desc(slot * 4 + 0, ctl);
    endtask

    task automatic expect_buf(input int ptr, input int len, input bit lst);
        for (int k = 0; k < len; k++) begin
            exp_bytes[exp_n] = bval(ptr + k);
            exp_n++;
        end
        if (lst) begin
            exp_eof[exp_eof_n] = exp_n;
            exp_eof_n++;
        end
    endtask

    task automatic wait_idle(input int slots);
        logic [15:0] w;
        bit busy;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            busy = 0;
            for (int s = 0; s < slots; s++) begin
                rd_desc(s * 4, w);
                if (w[15]) busy = 1;
            end
            if (!busy) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_run();
        got = 0; eof_n = 0; exp_n = 0; exp_eof_n = 0;
    endtask

    task automatic compare_stream(input string req);
        chk(got == exp_n, req, got, exp_n);
        for (int k = 0; k < exp_n && k < got; k++)
            chk(got_bytes[k] == exp_bytes[k], req, int'(got_bytes[k]), int'(exp_bytes[k]));
        chk(eof_n == exp_eof_n, req, eof_n, exp_eof_n);
        for (int k = 0; k < exp_eof_n && k < eof_n; k++)
            chk(eof_pos[k] == exp_eof[k], req, eof_pos[k], exp_eof[k]);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        int L, len, ptr;
        bit lst, itr, any_intr;
        logic [15:0] ctl;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(tx_valid == 1'b0, "R1 valid", int'(tx_valid), 0);
        chk(tx_eof == 1'b0, "R1 eof", int'(tx_eof), 0);
        chk(tx_event == 1'b0, "R1 event", int'(tx_event), 0);
        for (int a = 0; a < NUM_DESC * 4; a++) begin
            rd_desc(a, w);
            chk(w == 16'h0, "R1 desc mem", int'(w), 0);
        end

        // Buffer fill
        for (int a = 0; a < BUF_DEPTH; a++) begin
            @(negedge clk);
            buf_wr_addr = BUF_AW'(a);
            buf_wr_data = bval(a);
            buf_wr_en   = 1'b1;
        end
        @(negedge clk);
        buf_wr_en = 1'b0;

        // R3: slot 1 ready, slot 0 not: nothing may be sent
        clear_run();
        ready_pat = 0;
        put_desc(1, C_READY | C_WRAP | C_LAST, 3, 50);
        repeat (40) @(negedge clk);
        chk(got == 0, "R3 no skip", got, 0);
        rd_desc(4, w);
        chk(w[15] == 1'b1, "R3 slot1 untouched", int'(w), int'(C_READY | C_WRAP | C_LAST));
        put_desc(0, C_READY, 2, 60);
        wait_idle(2);
        expect_buf(60, 2, 0);
        expect_buf(50, 3, 1);
        compare_stream("R3/R5 two-buffer frame");
        chk(tx_event == 1'b0, "R9 no request no event", int'(tx_event), 0);

        // Sweep: ring length 1..4, lengths 0..5, three ready patterns
        for (int pass = 0; pass < 12; pass++) begin
            clear_run();
            ready_pat = (pass % 3 == 0) ? 0 : pass;
            any_intr = 0;
            L = (pass % 4) + 1;
            for (int i = 0; i < L; i++) begin
                len = (i * 3 + pass) % 6;
                lst = (i % 2 == 1) || (i == L - 1);
                itr = (i % 2 == 0) && (pass % 3 != 2);
                ctl = C_READY | ((i == L - 1) ? C_WRAP : 16'h0)
                    | (itr ? C_INTR : 16'h0) | (lst ? C_LAST : 16'h0);
                ctl_v[i] = ctl;
                ptr = i * 40 + pass * 3 + 65536 * (pass % 2);
                any_intr = any_intr | itr;
                put_desc(i, ctl, len, ptr);
                expect_buf(ptr % BUF_DEPTH, len, lst);
            end
            wait_idle(L);
            compare_stream("R2/R4/R5/R6/R8 sweep");
            for (int i = 0; i < L; i++) begin
                rd_desc(i * 4, w);
                chk(w == (ctl_v[i] & ~C_READY), "R7 retire word", int'(w), int'(ctl_v[i] & ~C_READY));
                rd_desc(i * 4 + 1, w);
                chk(w == 16'((i * 3 + pass) % 6), "R7 length kept", int'(w), (i * 3 + pass) % 6);
            end
            chk(tx_event == any_intr, "R9 event", int'(tx_event), int'(any_intr));
            pulse_clr();
            chk(tx_event == 1'b0, "R10 clear", int'(tx_event), 0);
        end

        // R11: abort in the middle of slot 0
        clear_run();
        ready_pat = 0;
        abort_at  = 3;
        abort_arm = 1;
        put_desc(1, C_READY | C_WRAP | C_LAST, 2, 10);
        put_desc(0, C_READY | C_LAST | C_INTR, 10, 200);
        wait_idle(2);
        expect_buf(200, 3, 0);
        expect_buf(10, 2, 1);
        compare_stream("R11 abort stream");
        rd_desc(0, w);
        chk(w == (C_LAST | C_INTR | C_ERR), "R11 error bit", int'(w), int'(C_LAST | C_INTR | C_ERR));
        rd_desc(4, w);
        chk(w == (C_WRAP | C_LAST), "R11 next slot retired", int'(w), int'(C_WRAP | C_LAST));
        chk(tx_event == 1'b1, "R9 event on abort", int'(tx_event), 1);

        finish_run();
    end

endmodule